// File: doc/BRIEF.md
# Software Write-Protection Command Detector

This block sits between the page-load sequencer of a parallel non-volatile memory and its array. It sees every captured write strobe (address and data) and a pulse that marks the close of each page-load window. From that stream it recognises an unlock/enable command and a longer disable command. It keeps a persistent protection flag, and for every closed load it issues a single verdict: may the latched page be committed to the array, or must the programming timer run as a dummy busy period that writes nothing.

A command is only recognised when its bytes are the first strobes of a load window. A command that is cut short when the window closes is dropped, and the next window starts matching from its first byte again. Each strobe that matched a command step is flagged so that the sequencer keeps it out of the page buffer. The command addresses stay ordinary writable locations: a strobe to them with other data is plain data. The protection flag survives the ordinary reset. Only a separate factory-reset input clears it.

Top module: `swprot_cmd_detect`

## Requirements
- R1: After the factory reset `prot_on` is 0, and after the ordinary reset `cmd_drop` and `commit_vld` are 0.
- R2: The strobes 8'hAA to 17'h15555, 8'h55 to 17'h0AAAA and 8'hA0 to 17'h15555, as the first three strobes of one load, set `prot_on` to 1 in the cycle after that load's `load_end`.
- R3: `cmd_drop` is 1 in the cycle after each strobe that matched the next expected command byte. It is 0 after data strobes that follow a completed command, and 0 in any cycle not preceded by a strobe.
- R4: While `prot_on` is 1, a load that does not begin with a complete command ends with `commit_ok` = 0, and `prot_on` stays 1.
- R5: While `prot_on` is 1, a load that begins with the three-byte enable command ends with `commit_ok` = 1, and `prot_on` stays 1.
- R6: While `prot_on` is 0, every load ends with `commit_ok` = 1.
- R7: The six strobes 8'hAA to 17'h15555, 8'h55 to 17'h0AAAA, 8'h80 to 17'h15555, 8'hAA to 17'h15555, 8'h55 to 17'h0AAAA and 8'h20 to 17'h15555, as the first strobes of one load, clear `prot_on` in the cycle after `load_end`, with `commit_ok` = 1. Each of the six strobes is flagged by `cmd_drop`.
- R8: When `load_end` arrives partway through a command, the command is abandoned. The flag does not change, and the next load starts matching at its first byte.
- R9: `prot_on` changes only on `load_end` or the factory reset. The ordinary reset leaves it unchanged.
- R10: A strobe that does not match the expected command byte is data and is not flagged. For the rest of that load, no command byte is recognised.
- R11: `commit_vld` is 1 for exactly the cycle after each `load_end` and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary asynchronous reset, active low; keeps the protection flag |
| factory_rst_n | input | 1 | Asynchronous factory reset, active low; clears the protection flag |
| wr_stb | input | 1 | One-cycle pulse per captured write strobe |
| wr_addr | input | 17 | Address of the captured strobe |
| wr_data | input | 8 | Data of the captured strobe |
| load_end | input | 1 | One-cycle pulse when the page-load window closes |
| cmd_drop | output | 1 | Previous-cycle strobe was a command byte; keep it out of the page |
| commit_vld | output | 1 | Verdict for the load that just closed is valid |
| commit_ok | output | 1 | Latched page may be written; 0 means dummy busy period only |
| prot_on | output | 1 | Current protection state |

## Verification
The assertions take for granted that `wr_stb` and `load_end` are never high in the same cycle, because the sequencer closes a window only after its last strobe has been captured. One assertion restates this so that a stimulus breaking it is caught. The bench drives every strobe and every window close as a separate one-cycle pulse on a falling edge, with at least one idle cycle between them, so that condition always holds. It also releases the factory reset before the first load, so the hold check on the flag starts from a known value.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int ADDR_W   = 17;
  localparam int DATA_W   = 8;
  localparam int NSTEP    = 6;   // length of the disable command
  localparam int ENA_STEP = 2;   // step at which the enable command may finish
  localparam int STEP_W   = $clog2(NSTEP + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {
    TRK_MATCH    = 2'd0,
    TRK_BROKEN   = 2'd1,
    TRK_ENABLED  = 2'd2,
    TRK_DISABLED = 2'd3
  } trk_e;

  // Address expected at a given step of the long command.
  function automatic addr_t seq_addr(input int idx, input addr_t ax, input addr_t ay);
    return (idx == 1 || idx == 4) ? ay : ax;
  endfunction

  // Data expected at a given step of the long command.
  function automatic data_t seq_data(input int idx, input data_t k1, input data_t k2,
                                     input data_t d1, input data_t d2);
    case (idx)
      0, 3:    return k1;
      1, 4:    return k2;
      2:       return d1;
      default: return d2;
    endcase
  endfunction

  // Verdict for a closed load.
  function automatic logic commit_allowed(input logic prot, input logic ena, input logic dis);
    return !prot || ena || dis;
  endfunction

  // Next value of the persistent flag at a load close.
  function automatic logic prot_next(input logic prot, input logic ena, input logic dis);
    if (ena) return 1'b1;
    if (dis) return 1'b0;
    return prot;
  endfunction
endpackage

// File: rtl/swp_seq_tracker.sv
module swp_seq_tracker
  import swp_pkg::*;
#(
  parameter addr_t ADDR_X  = 17'h15555,
  parameter addr_t ADDR_Y  = 17'h0AAAA,
  parameter data_t KEY_1   = 8'hAA,
  parameter data_t KEY_2   = 8'h55,
  parameter data_t ENA_KEY = 8'hA0,
  parameter data_t DIS_K1  = 8'h80,
  parameter data_t DIS_K2  = 8'h20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_stb,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  logic  load_end,
  output logic  step_hit,
  output logic  seq_enabled,
  output logic  seq_disabled,
  output logic  cmd_drop
);
  logic [NSTEP-1:0]  step_match;
  logic [STEP_W-1:0] step_q;
  trk_e              st_q;
  logic              ena_hit;
  logic              sel_match;

  // One comparator per step of the long command.
  for (genvar gi = 0; gi < NSTEP; gi++) begin : g_step
    assign step_match[gi] = (wr_addr == seq_addr(gi, ADDR_X, ADDR_Y)) &&
                            (wr_data == seq_data(gi, KEY_1, KEY_2, DIS_K1, DIS_K2));
  end

  always_comb begin
    sel_match = 1'b0;
    for (int i = 0; i < NSTEP; i++)
      if (step_q == STEP_W'(i)) sel_match = step_match[i];
  end

  assign ena_hit  = (st_q == TRK_MATCH) && (step_q == STEP_W'(ENA_STEP)) &&
                    (wr_addr == ADDR_X) && (wr_data == ENA_KEY);
  assign step_hit = wr_stb && (st_q == TRK_MATCH) && (sel_match || ena_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= TRK_MATCH;
      step_q   <= '0;
      cmd_drop <= 1'b0;
    end else begin
      cmd_drop <= step_hit;
      if (load_end) begin
        st_q   <= TRK_MATCH;
        step_q <= '0;
      end else if (wr_stb && st_q == TRK_MATCH) begin
        if (ena_hit)
          st_q <= TRK_ENABLED;
        else if (sel_match) begin
          if (step_q == STEP_W'(NSTEP - 1)) st_q <= TRK_DISABLED;
          else                              step_q <= step_q + 1'b1;
        end else
          st_q <= TRK_BROKEN;
      end
    end
  end

  assign seq_enabled  = (st_q == TRK_ENABLED);
  assign seq_disabled = (st_q == TRK_DISABLED);
endmodule

// File: rtl/swp_prot_flag.sv
module swp_prot_flag
  import swp_pkg::*;
(
  input  logic clk,
  input  logic factory_rst_n,
  input  logic load_end,
  input  logic seq_enabled,
  input  logic seq_disabled,
  output logic prot_on
);
  always_ff @(posedge clk or negedge factory_rst_n) begin
    if (!factory_rst_n)
      prot_on <= 1'b0;
    else if (load_end)
      prot_on <= prot_next(prot_on, seq_enabled, seq_disabled);
  end
endmodule

// File: rtl/swp_commit_gate.sv
module swp_commit_gate
  import swp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_end,
  input  logic prot_on,
  input  logic seq_enabled,
  input  logic seq_disabled,
  output logic commit_vld,
  output logic commit_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_vld <= 1'b0;
      commit_ok  <= 1'b0;
    end else begin
      commit_vld <= load_end;
      if (load_end)
        commit_ok <= commit_allowed(prot_on, seq_enabled, seq_disabled);
    end
  end
endmodule

// File: rtl/swprot_cmd_detect.sv
module swprot_cmd_detect
  import swp_pkg::*;
#(
  parameter addr_t ADDR_X  = 17'h15555,
  parameter addr_t ADDR_Y  = 17'h0AAAA,
  parameter data_t KEY_1   = 8'hAA,
  parameter data_t KEY_2   = 8'h55,
  parameter data_t ENA_KEY = 8'hA0,
  parameter data_t DIS_K1  = 8'h80,
  parameter data_t DIS_K2  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factory_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_end,
  output logic              cmd_drop,
  output logic              commit_vld,
  output logic              commit_ok,
  output logic              prot_on
);
  // Named internal events, visible to the bound checker.
  logic ev_hit;
  logic ev_enable;
  logic ev_disable;

  swp_seq_tracker #(
    .ADDR_X(ADDR_X), .ADDR_Y(ADDR_Y), .KEY_1(KEY_1), .KEY_2(KEY_2),
    .ENA_KEY(ENA_KEY), .DIS_K1(DIS_K1), .DIS_K2(DIS_K2)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_end(load_end), .step_hit(ev_hit),
    .seq_enabled(ev_enable), .seq_disabled(ev_disable), .cmd_drop(cmd_drop)
  );

  swp_prot_flag u_flag (
    .clk(clk), .factory_rst_n(factory_rst_n), .load_end(load_end),
    .seq_enabled(ev_enable), .seq_disabled(ev_disable), .prot_on(prot_on)
  );

  swp_commit_gate u_gate (
    .clk(clk), .rst_n(rst_n), .load_end(load_end), .prot_on(prot_on),
    .seq_enabled(ev_enable), .seq_disabled(ev_disable),
    .commit_vld(commit_vld), .commit_ok(commit_ok)
  );
endmodule

// File: rtl/swprot_checker.sv
module swprot_checker (
  input logic clk,
  input logic rst_n,
  input logic factory_rst_n,
  input logic wr_stb,
  input logic load_end,
  input logic ev_hit,
  input logic ev_enable,
  input logic ev_disable,
  input logic cmd_drop,
  input logic commit_vld,
  input logic commit_ok,
  input logic prot_on
);
  // Input condition: a window closes only after its last strobe.
  assert_stb_load_apart_R8: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) !(wr_stb && load_end));

  assert_verdict_pulse_R11: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) load_end |=> commit_vld);

  assert_verdict_quiet_R11: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) !load_end |=> !commit_vld);

  assert_enable_sets_R2: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) (load_end && ev_enable) |=> prot_on);

  assert_disable_clears_R7: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) (load_end && ev_disable) |=> (!prot_on && commit_ok));

  assert_blocked_load_R4: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n)
    (load_end && prot_on && !ev_enable && !ev_disable) |=> (!commit_ok && prot_on));

  assert_open_load_R6: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) (load_end && !prot_on) |=> commit_ok);

  assert_flag_holds_R9: assert property (@(posedge clk)
    disable iff (!factory_rst_n) !load_end |=> $stable(prot_on));

  assert_drop_follows_hit_R3: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) ev_hit |=> cmd_drop);

  assert_drop_needs_stb_R3: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) !wr_stb |=> !cmd_drop);

  assert_events_exclusive_R10: assert property (@(posedge clk)
    disable iff (!rst_n || !factory_rst_n) !(ev_enable && ev_disable));
endmodule

bind swprot_cmd_detect swprot_checker u_chk (.*);

// File: tb/sim_swprot_cmd_detect.sv
module sim_swprot_cmd_detect;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] AX = 17'h15555;
  localparam logic [16:0] AY = 17'h0AAAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        factory_rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        load_end = 1'b0;
  logic        cmd_drop, commit_vld, commit_ok, prot_on;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swprot_cmd_detect u0 (
    .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .load_end(load_end),
    .cmd_drop(cmd_drop), .commit_vld(commit_vld), .commit_ok(commit_ok), .prot_on(prot_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One strobe; cmd_drop is checked one edge later.
  task automatic stb(input logic [16:0] a, input logic [7:0] d, input logic exp_drop, input string req);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(req, cmd_drop, exp_drop);
  endtask

  // Close a window and check the verdict and flag one edge later.
  task automatic close_load(input logic exp_ok, input logic exp_prot, input string req);
    @(negedge clk);
    load_end = 1'b1;
    @(negedge clk);
    load_end = 1'b0;
    chk({req, " vld"}, commit_vld, 1'b1);
    chk({req, " ok"}, commit_ok, exp_ok);
    chk({req, " prot"}, prot_on, exp_prot);
  endtask

  task automatic enable_cmd(input logic exp_drop);
    stb(AX, 8'hAA, exp_drop, "R3 cmd1");
    stb(AY, 8'h55, exp_drop, "R3 cmd2");
    stb(AX, 8'hA0, exp_drop, "R3 cmd3");
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    factory_rst_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prot", prot_on, 1'b0);
    chk("R1 drop", cmd_drop, 1'b0);
    chk("R1 vld", commit_vld, 1'b0);
  endtask

  task automatic t_open_write;
    stb(17'h00123, 8'h5A, 1'b0, "R6 data");
    stb(AX, 8'h77, 1'b0, "R10 cmd addr as data");
    close_load(1'b1, 1'b0, "R6");
    @(negedge clk);
    chk("R11 vld drops", commit_vld, 1'b0);
  endtask

  task automatic t_enable;
    enable_cmd(1'b1);
    stb(17'h01000, 8'h33, 1'b0, "R3 data after cmd");
    close_load(1'b1, 1'b1, "R2");
  endtask

  task automatic t_blocked;
    stb(17'h00200, 8'h44, 1'b0, "R4 data");
    close_load(1'b0, 1'b1, "R4");
  endtask

  task automatic t_unlocked;
    enable_cmd(1'b1);
    stb(17'h00300, 8'h12, 1'b0, "R5 data");
    stb(17'h00301, 8'h34, 1'b0, "R5 data");
    close_load(1'b1, 1'b1, "R5");
  endtask

  task automatic t_abandon;
    stb(AX, 8'hAA, 1'b1, "R8 part1");
    stb(AY, 8'h55, 1'b1, "R8 part2");
    close_load(1'b0, 1'b1, "R8 cut");
    stb(AX, 8'hA0, 1'b0, "R8 restart");
    close_load(1'b0, 1'b1, "R8 next");
  endtask

  task automatic t_broken;
    stb(17'h00010, 8'h11, 1'b0, "R10 lead data");
    enable_cmd(1'b0);
    close_load(1'b0, 1'b1, "R10");
  endtask

  task automatic t_plain_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 during rst", prot_on, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after rst", prot_on, 1'b1);
    chk("R1 vld after rst", commit_vld, 1'b0);
  endtask

  task automatic t_disable;
    stb(AX, 8'hAA, 1'b1, "R7 b1");
    stb(AY, 8'h55, 1'b1, "R7 b2");
    stb(AX, 8'h80, 1'b1, "R7 b3");
    stb(AX, 8'hAA, 1'b1, "R7 b4");
    stb(AY, 8'h55, 1'b1, "R7 b5");
    stb(AX, 8'h20, 1'b1, "R7 b6");
    close_load(1'b1, 1'b0, "R7");
    stb(17'h00400, 8'h66, 1'b0, "R6 after off");
    close_load(1'b1, 1'b0, "R6 after off");
  endtask

  task automatic t_factory;
    enable_cmd(1'b1);
    close_load(1'b1, 1'b1, "R2 again");
    @(negedge clk);
    factory_rst_n = 1'b0;
    @(negedge clk);
    factory_rst_n = 1'b1;
    @(negedge clk);
    chk("R9 factory clear", prot_on, 1'b0);
  endtask

  initial begin
    t_reset();
    t_open_write();
    t_enable();
    t_blocked();
    t_unlocked();
    t_abandon();
    t_broken();
    t_plain_reset();
    t_disable();
    t_factory();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule